// File: doc/BRIEF.md
# Nonvolatile Configuration Bit Controller

This block manages a small bank of general-purpose configuration bits and one security flag. Both sit in internal registers, so no flash array is attached. Software writes a 32-bit command word to the command register. The word holds an access key, an opcode and a bit index. The controller checks the word and, if it is accepted, runs a timed programming operation that lasts a fixed number of cycles. When the operation completes, the controller applies the change and raises its ready flag. A ready interrupt can be enabled through the mode register.

Once the security flag is set, no command can clear it. While it is set, the controller holds a debug-lockout output that shuts the external test and programming ports. Only the external erase input removes the flag. The erase clears every configuration bit first, and the flag drops one cycle later. A separate handshake shows that array reads are still served while a programming operation runs.

Top module: `nvcfg_ctrl`

## Requirements
- R1: The write address map is mode = 0, command = 1, and status = 2 for reads. In a command word, bits [31:24] carry the key (8'h5A), bits [17:8] carry the bit index and bits [3:0] carry the opcode (4'hB set bit, 4'hD clear bit, 4'hF set security). An accepted command drops ready (status bit 0) on the edge that takes the write. Ready stays low for exactly BUSY_CYCLES cycles and then rises.
- R2: On completion, a set-bit command makes status bit 8+n read 1 and a clear-bit command makes it read 0, where n is the bit index.
- R3: A set-bit or clear-bit command whose index is NUM_GP or larger still runs the full timed operation but changes no configuration bit.
- R4: A wrong key or an opcode outside the three listed sets the programming-error flag (status bit 3) and starts no operation, so ready stays 1.
- R5: A command written while an operation or an erase is in progress is ignored and sets the programming-error flag.
- R6: A status read returns the programming-error flag and then clears it. If a new error arises in the same cycle as the read, the read returns the old value and the flag stays set.
- R7: The irq output equals ready AND the interrupt-enable bit (mode register bit 0, which reads back at bit 0).
- R8: The set-security command sets status bit 4 on completion. No command clears that bit, and debug_lock is high whenever it is set.
- R9: An erase request clears all configuration bits on the edge that samples it and aborts any running operation. The security bit drops on the next edge. If a command completes on the same edge as the erase, the erase wins.
- R10: arr_rd_ack goes high one cycle after arr_rd_req, whether or not an operation is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Registered read data, valid the cycle after rd_en |
| erase_req | input | 1 | External erase request |
| arr_rd_req | input | 1 | Array read request |
| arr_rd_ack | output | 1 | Array read acknowledge |
| irq | output | 1 | Ready interrupt |
| debug_lock | output | 1 | Debug and programming port lockout |

## Verification
Two pairs of functions can land on one edge. In the first, an erase request arrives on the exact edge where a set-bit command would complete. The bench raises the erase BUSY_CYCLES-1 cycles after the write. It then issues a status read that is captured one edge later, which should show the bits already wiped while security still reads 1, with debug_lock falling right after. In the second, a status read and a rejected command share a cycle. The read must report the old, clear error flag, and the next read must report it set.

// File: rtl/nvcfg_pkg.sv
`timescale 1ns/1ps
package nvcfg_pkg;
  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_CMD  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  localparam logic [3:0] OP_SETGP  = 4'hB;
  localparam logic [3:0] OP_CLRGP  = 4'hD;
  localparam logic [3:0] OP_SETSEC = 4'hF;

  localparam int ST_RDY = 0;
  localparam int ST_ERR = 3;
  localparam int ST_SEC = 4;
  localparam int ST_GP  = 8;

  localparam int KEY_LSB = 24;
  localparam int IDX_LSB = 8;
  localparam int IDX_FW  = 10;
endpackage

// File: rtl/nvcfg_cmd_dec.sv
`timescale 1ns/1ps
module nvcfg_cmd_dec
  import nvcfg_pkg::*;
#(
  parameter int          NUM_GP = 3,
  parameter logic [7:0]  KEY    = 8'h5A,
  localparam int         IDX_W  = (NUM_GP > 1) ? $clog2(NUM_GP) : 1
) (
  input  logic [31:0]      word,
  output logic             key_ok,
  output logic             op_ok,
  output logic             in_range,
  output logic [3:0]       op,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_FW-1:0] IDX_LIM = IDX_FW'(NUM_GP);

  logic [IDX_FW-1:0] idx_field;

  assign idx_field = word[IDX_LSB +: IDX_FW];
  assign op        = word[3:0];
  assign key_ok    = (word[KEY_LSB +: 8] == KEY);
  assign op_ok     = (op == OP_SETGP) || (op == OP_CLRGP) || (op == OP_SETSEC);
  assign in_range  = (idx_field < IDX_LIM);
  assign idx       = idx_field[IDX_W-1:0];
endmodule

// File: rtl/nvcfg_timer.sv
`timescale 1ns/1ps
module nvcfg_timer #(
  parameter int BUSY_CYCLES = 16,
  localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (abort) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= CNT_W'(BUSY_CYCLES - 1);
    end else if (busy) begin
      if (cnt_q == '0) busy  <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = busy && (cnt_q == '0);
endmodule

// File: rtl/nvcfg_bits.sv
`timescale 1ns/1ps
module nvcfg_bits
  import nvcfg_pkg::*;
#(
  parameter int  NUM_GP = 3,
  localparam int IDX_W  = (NUM_GP > 1) ? $clog2(NUM_GP) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [3:0]        op,
  input  logic [IDX_W-1:0]  idx,
  input  logic              in_range,
  input  logic              done,
  input  logic              erase_go,
  output logic [NUM_GP-1:0] gp_q,
  output logic              sec_q,
  output logic              wiping
);
  logic [3:0]       pend_op;
  logic [IDX_W-1:0] pend_idx;
  logic             pend_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      gp_q     <= '0;
      sec_q    <= 1'b0;
      wiping   <= 1'b0;
      pend_op  <= '0;
      pend_idx <= '0;
      pend_hit <= 1'b0;
    end else if (erase_go) begin
      gp_q   <= '0;
      wiping <= 1'b1;
    end else if (wiping) begin
      sec_q  <= 1'b0;
      wiping <= 1'b0;
    end else begin
      if (start) begin
        pend_op  <= op;
        pend_idx <= idx;
        pend_hit <= in_range;
      end
      if (done) begin
        case (pend_op)
          OP_SETGP:  if (pend_hit) gp_q[pend_idx] <= 1'b1;
          OP_CLRGP:  if (pend_hit) gp_q[pend_idx] <= 1'b0;
          OP_SETSEC: sec_q <= 1'b1;
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/nvcfg_ctrl.sv
`timescale 1ns/1ps
module nvcfg_ctrl
  import nvcfg_pkg::*;
#(
  parameter int         NUM_GP      = 3,
  parameter int         BUSY_CYCLES = 16,
  parameter logic [7:0] KEY         = 8'h5A
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        erase_req,
  input  logic        arr_rd_req,
  output logic        arr_rd_ack,
  output logic        irq,
  output logic        debug_lock
);
  localparam int IDX_W = (NUM_GP > 1) ? $clog2(NUM_GP) : 1;

  logic              key_ok, op_ok, in_range;
  logic [3:0]        op;
  logic [IDX_W-1:0]  idx;
  logic              busy, done, wiping, sec_q;
  logic [NUM_GP-1:0] gp_q;
  logic              ien_q, err_q;
  logic              cmd_wr, erase_go, blocked, accept, fault, stat_rd;
  logic [31:0]       stat_w;

  nvcfg_cmd_dec #(.NUM_GP(NUM_GP), .KEY(KEY)) dec_i (
    .word(wr_data), .key_ok(key_ok), .op_ok(op_ok),
    .in_range(in_range), .op(op), .idx(idx)
  );

  assign cmd_wr   = wr_en && (wr_addr == A_CMD);
  assign erase_go = erase_req && !wiping;
  assign blocked  = busy || wiping || erase_go;
  assign accept   = cmd_wr && key_ok && op_ok && !blocked;
  assign fault    = cmd_wr && (!(key_ok && op_ok) || blocked);
  assign stat_rd  = rd_en && (rd_addr == A_STAT);

  nvcfg_timer #(.BUSY_CYCLES(BUSY_CYCLES)) tmr_i (
    .clk(clk), .rst(rst), .start(accept), .abort(erase_go),
    .busy(busy), .done(done)
  );

  nvcfg_bits #(.NUM_GP(NUM_GP)) bits_i (
    .clk(clk), .rst(rst), .start(accept), .op(op), .idx(idx),
    .in_range(in_range), .done(done), .erase_go(erase_go),
    .gp_q(gp_q), .sec_q(sec_q), .wiping(wiping)
  );

  always_comb begin
    stat_w                   = '0;
    stat_w[ST_RDY]           = !busy;
    stat_w[ST_ERR]           = err_q;
    stat_w[ST_SEC]           = sec_q;
    stat_w[ST_GP +: NUM_GP]  = gp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q      <= 1'b0;
      err_q      <= 1'b0;
      rd_data    <= '0;
      arr_rd_ack <= 1'b0;
    end else begin
      if (wr_en && (wr_addr == A_MODE)) ien_q <= wr_data[0];
      if (fault)        err_q <= 1'b1;
      else if (stat_rd) err_q <= 1'b0;
      if (rd_en) begin
        case (rd_addr)
          A_MODE:  rd_data <= {31'd0, ien_q};
          A_STAT:  rd_data <= stat_w;
          default: rd_data <= '0;
        endcase
      end
      arr_rd_ack <= arr_rd_req;
    end
  end

  assign irq        = !busy && ien_q;
  assign debug_lock = sec_q;
endmodule

// File: rtl/nvcfg_ctrl_chk.sv
`timescale 1ns/1ps
module nvcfg_ctrl_chk
  import nvcfg_pkg::*;
#(
  parameter int         NUM_GP = 3,
  parameter logic [7:0] KEY    = 8'h5A
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [31:0]       wr_data,
  input logic              erase_req,
  input logic              arr_rd_req,
  input logic              arr_rd_ack,
  input logic              busy,
  input logic              wiping,
  input logic              sec,
  input logic [NUM_GP-1:0] gp,
  input logic              err
);
  logic cmd_w, good_w;
  assign cmd_w  = wr_en && (wr_addr == A_CMD);
  assign good_w = (wr_data[31:24] == KEY) &&
                  ((wr_data[3:0] == OP_SETGP) || (wr_data[3:0] == OP_CLRGP) ||
                   (wr_data[3:0] == OP_SETSEC));

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    cmd_w && good_w && !busy && !wiping && !erase_req |=> busy); // R1
  AST_BAD_KEY_ERR: assert property (@(posedge clk) disable iff (rst)
    cmd_w && (wr_data[31:24] != KEY) |=> err && !$rose(busy)); // R4
  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (rst)
    cmd_w && busy |=> err); // R5
  AST_SEC_SET_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(sec) |-> $past(busy)); // R8
  AST_SEC_DROP_AFTER_WIPE: assert property (@(posedge clk) disable iff (rst)
    $fell(sec) |-> (gp == '0) && $past(wiping)); // R9
  AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    erase_req && !wiping |=> (gp == '0) && !busy); // R9
  AST_ARR_ACK: assert property (@(posedge clk) disable iff (rst)
    arr_rd_req |=> arr_rd_ack); // R10
endmodule

bind nvcfg_ctrl nvcfg_ctrl_chk #(.NUM_GP(NUM_GP), .KEY(KEY)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .erase_req(erase_req), .arr_rd_req(arr_rd_req), .arr_rd_ack(arr_rd_ack),
  .busy(busy), .wiping(wiping), .sec(sec_q), .gp(gp_q), .err(err_q)
);

// File: tb/nvcfg_ctrl_tb_top.sv
`timescale 1ns/1ps
module nvcfg_ctrl_tb_top;
  localparam int         NUM_GP = 3;
  localparam int         BUSY   = 16;
  localparam logic [7:0] KEY    = 8'h5A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        erase_req = 1'b0, arr_rd_req = 1'b0;
  logic        arr_rd_ack, irq, debug_lock;

  int n_chk = 0, n_bad = 0;
  bit fin = 1'b0;
  logic [NUM_GP-1:0] m_gp = '0;
  bit m_sec = 1'b0, m_err = 1'b0;

  always #2 clk = ~clk;

  nvcfg_ctrl #(.NUM_GP(NUM_GP), .BUSY_CYCLES(BUSY), .KEY(KEY)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .erase_req(erase_req),
    .arr_rd_req(arr_rd_req), .arr_rd_ack(arr_rd_ack), .irq(irq),
    .debug_lock(debug_lock)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat(bit rdy);
    logic [31:0] s = '0;
    s[0] = rdy; s[3] = m_err; s[4] = m_sec; s[8 +: NUM_GP] = m_gp;
    return s;
  endfunction

  function automatic logic [31:0] mk_cmd(logic [7:0] k, logic [3:0] op, logic [9:0] idx);
    return {k, 6'd0, idx, 4'd0, op};
  endfunction

  function automatic bit good_cmd(logic [31:0] w);
    return (w[31:24] == KEY) && (w[3:0] == 4'hB || w[3:0] == 4'hD || w[3:0] == 4'hF);
  endfunction

  function automatic void apply_cmd(logic [31:0] w);
    int i = int'(w[17:8]);
    if (w[3:0] == 4'hB && i < NUM_GP) m_gp[i] = 1'b1;
    if (w[3:0] == 4'hD && i < NUM_GP) m_gp[i] = 1'b0;
    if (w[3:0] == 4'hF) m_sec = 1'b1;
  endfunction

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!irq && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic read_status(string tag);
    logic [31:0] s;
    reg_read(2'd2, s);
    check(s == exp_stat(1'b1), tag, s, exp_stat(1'b1));
    m_err = 1'b0;
  endtask

  // One full command: timing, optional busy collision, status and lockout.
  task automatic do_cmd(logic [31:0] w, bit collide, string tag);
    int n, pre;
    if (!good_cmd(w)) begin
      reg_write(2'd1, w);
      m_err = 1'b1;
      check(irq == 1'b1, {tag, " R4 no start"}, 32'(irq), 32'd1);
    end else begin
      reg_write(2'd1, w);
      check(irq == 1'b0, {tag, " R1 ready drop"}, 32'(irq), 32'd0);
      pre = 0;
      if (collide) begin
        arr_rd_req = 1'b1; @(negedge clk); arr_rd_req = 1'b0;
        check(arr_rd_ack == 1'b1, "R10 ack while busy", 32'(arr_rd_ack), 32'd1);
        @(negedge clk);
        check(arr_rd_ack == 1'b0, "R10 ack drop", 32'(arr_rd_ack), 32'd0);
        @(negedge clk);
        reg_write(2'd1, mk_cmd(KEY, 4'hB, 10'd0));
        m_err = 1'b1;
        pre = 4;
      end
      wait_ready(n);
      check(n + pre == BUSY, {tag, " R1 busy length"}, 32'(n + pre), 32'(BUSY));
      apply_cmd(w);
    end
    read_status({tag, " R2 status"});
    check(debug_lock == m_sec, {tag, " R8 lock"}, 32'(debug_lock), 32'(m_sec));
  endtask

  initial begin
    logic [31:0] d;
    int cyc;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    check(irq == 1'b0 && debug_lock == 1'b0 && arr_rd_ack == 1'b0, "R7 reset outputs",
          {29'd0, irq, debug_lock, arr_rd_ack}, 32'd0);
    read_status("R1 reset status");

    reg_write(2'd0, 32'd1);
    check(irq == 1'b1, "R7 irq on enable", 32'(irq), 32'd1);
    reg_read(2'd0, d);
    check(d == 32'd1, "R7 mode readback", d, 32'd1);

    do_cmd(mk_cmd(KEY, 4'hB, 10'd1), 1'b0, "R2 set1");
    do_cmd(mk_cmd(KEY, 4'hB, 10'd2), 1'b0, "R2 set2");
    do_cmd(mk_cmd(KEY, 4'hD, 10'd1), 1'b0, "R2 clr1");
    do_cmd(mk_cmd(KEY, 4'hB, 10'd3), 1'b0, "R3 idx3");
    do_cmd(mk_cmd(KEY, 4'hD, 10'h3FF), 1'b0, "R3 idx3ff");
    do_cmd(mk_cmd(8'hA5, 4'hB, 10'd0), 1'b0, "R4 badkey");
    read_status("R6 cleared after read");
    do_cmd(mk_cmd(KEY, 4'h3, 10'd0), 1'b0, "R4 badop");
    do_cmd(mk_cmd(KEY, 4'hB, 10'd0), 1'b1, "R5 busy write");

    // R6: read and rejected write in the same cycle
    rd_en = 1'b1; rd_addr = 2'd2;
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = mk_cmd(8'h00, 4'hB, 10'd0);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check(rd_data[3] == 1'b0, "R6 same-cycle read old", 32'(rd_data[3]), 32'd0);
    m_err = 1'b1;
    read_status("R6 error held");
    read_status("R6 error cleared");

    reg_write(2'd0, 32'd0);
    check(irq == 1'b0, "R7 irq masked", 32'(irq), 32'd0);
    reg_write(2'd0, 32'd1);

    for (int it = 0; it < 60; it++) begin
      logic [7:0] k;
      logic [3:0] op;
      int sel;
      k = KEY;
      if ($urandom % 5 == 0) begin k = 8'($urandom); if (k == KEY) k = k ^ 8'h01; end
      sel = int'($urandom % 8);
      op = (sel < 3) ? 4'hB : (sel < 6) ? 4'hD : (sel == 6) ? 4'($urandom) : 4'hF;
      if (op == 4'hF && $urandom % 2 == 0) op = 4'hB;
      do_cmd({k, 6'($urandom), 10'($urandom % 6), 4'($urandom), op},
             ($urandom % 4) == 0, "R2 random");
    end

    do_cmd(mk_cmd(KEY, 4'hF, 10'd0), 1'b0, "R8 set security");
    do_cmd(mk_cmd(KEY, 4'hD, 10'd0), 1'b0, "R8 clear no effect on security");
    do_cmd(mk_cmd(KEY, 4'hB, 10'd2), 1'b0, "R9 prep");

    // R9: erase on the completion edge of a set command
    reg_write(2'd1, mk_cmd(KEY, 4'hB, 10'd0));
    repeat (BUSY - 1) @(negedge clk);
    erase_req = 1'b1;
    @(negedge clk);
    erase_req = 1'b0;
    rd_en = 1'b1; rd_addr = 2'd2;
    check(debug_lock == 1'b1, "R9 security held one cycle", 32'(debug_lock), 32'd1);
    check(irq == 1'b1, "R9 operation aborted", 32'(irq), 32'd1);
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_data == 32'h11, "R9 bits wiped before security", rd_data, 32'h11);
    check(debug_lock == 1'b0, "R9 security dropped", 32'(debug_lock), 32'd0);
    m_gp = '0; m_sec = 1'b0;
    read_status("R9 status after erase");

    cyc = 0;
    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule